// File: doc/BRIEF.md
# Filtered Quadrature Encoder Front End

This block sits between the raw pins of an incremental encoder and a position counter. It brings channels A and B and the index line into the clock domain and cleans A and B with a majority filter. It then issues one-cycle count strobes that carry a direction, and the counter core adds or subtracts on each strobe. It has two operating modes. In quadrature mode the two channels are decoded as a two-bit Gray sequence, and the resolution can be one, two or four counts per encoder cycle. In clock/direction mode, channel A is a plain count clock and channel B gives the direction.

Alongside the strobes, the block keeps a sticky noise flag for illegal quadrature jumps and a direction status bit. It also produces an index event. That event either follows the index level directly (active low) or is qualified by a count strobe, with the polarity chosen by configuration.

Top module: `quad_front`

## Requirements
- R1: With `quadMode` = 0, each rising edge of synchronized A gives one `countEn` pulse. `countUp` equals synchronized B (1 = up). The pulse appears two clock edges after the edge that samples A high.
- R2: With `quadMode` = 1, A and B pass through a 3-sample majority filter. A level held for only one sample produces no count.
- R3: In quadrature mode, the phase pair written (A,B) steps 00→10→11→01→00 when counting up and in reverse when counting down. With `resSel` = 2 (x4), every legal step gives one count.
- R4: With `resSel` = 1 (x2), only steps in which A changes give a count.
- R5: With `resSel` = 0 (x1), only A steps taken while B = 0 give a count. The value `resSel` = 3 behaves as x1.
- R6: With `quadMode` = 0, `resSel` and `idxSync` have no effect: counting stays x1 and the index stays non-synchronous.
- R7: In quadrature mode, a filtered step in which A and B change together produces no count and sets `noiseErr`. The flag holds until `clrNoise` is sampled high in a cycle with no new illegal step, and a new illegal step wins over a clear. In clock/direction mode the flag is never set.
- R8: `dirUp` is 1 after reset and takes the direction of every count strobe. It holds between strobes.
- R9: In non-synchronous index mode, `idxEvent` is high exactly while the synchronized index input is low.
- R10: In synchronous index mode (`quadMode` = 1 and `idxSync` = 1), `idxEvent` pulses only together with `countEn`, and only if the index is at its active level. `idxPolarity` = 1 makes high the active level and 0 makes low the active level.
- R11: While reset is held, and on the first cycle after it, `countEn`, `countUp`, `noiseErr` and `idxEvent` are 0 and `dirUp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Encoder channel A / count clock |
| encB | input | 1 | Encoder channel B / direction |
| encIdx | input | 1 | Encoder index line |
| quadMode | input | 1 | 1 = quadrature decode, 0 = clock/direction |
| resSel | input | 2 | Resolution: 0 = x1, 1 = x2, 2 = x4, 3 = x1 |
| idxSync | input | 1 | 1 = index qualified by count strobes |
| idxPolarity | input | 1 | Active index level in synchronous mode |
| clrNoise | input | 1 | Clears the noise flag |
| countEn | output | 1 | One-cycle count strobe |
| countUp | output | 1 | Direction of the current strobe (1 = up) |
| dirUp | output | 1 | Direction of the last strobe |
| noiseErr | output | 1 | Sticky illegal-transition flag |
| idxEvent | output | 1 | Index action request |

## Verification
The properties assume that configuration inputs change only on the inactive clock edge, and that the encoder lines carry their stated meaning for the selected mode. The bench drives every input at the falling edge. It holds each quadrature phase for three cycles, so that the filter passes it, except where a glitch or a simultaneous A/B change is applied on purpose. Mode switches are made while the encoder lines are idle, so that a count strobe decided under one mode is never judged under the other by the single-cycle-lookback properties.

// File: rtl/quad_front_pkg.sv
package quad_front_pkg;

  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_RSV = 2'd3
  } resT;

  // Samples handed from the input front end to the decode control
  typedef struct packed {
    logic fltA;      // filtered A, current
    logic fltB;      // filtered B, current
    logic prvA;      // filtered A, one sample older
    logic prvB;      // filtered B, one sample older
    logic rawA;      // synchronized A, unfiltered
    logic rawAPrev;  // synchronized A, one sample older
    logic rawB;      // synchronized B, unfiltered
    logic idx;       // synchronized index
  } sampleT;

endpackage

// File: rtl/quad_front_input.sv
module quad_front_input
  import quad_front_pkg::*;
#(
  parameter int SYNC_DEPTH  = 2,
  parameter int FILTER_TAPS = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   encA,
  input  logic   encB,
  input  logic   encIdx,
  output sampleT smp
);

  localparam int MAJ = FILTER_TAPS / 2 + 1;
  localparam int CW  = $clog2(FILTER_TAPS + 1);

  logic [SYNC_DEPTH-1:0]  syncA, syncB, syncI;
  logic [FILTER_TAPS-1:0] winA, winB;
  logic                   fltA, fltB, prvA, prvB;
  logic [CW-1:0]          onesA, onesB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncI <= '1;
    end else begin
      syncA <= {syncA[SYNC_DEPTH-2:0], encA};
      syncB <= {syncB[SYNC_DEPTH-2:0], encB};
      syncI <= {syncI[SYNC_DEPTH-2:0], encIdx};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winA <= '0;
      winB <= '0;
    end else begin
      winA <= {winA[FILTER_TAPS-2:0], syncA[SYNC_DEPTH-1]};
      winB <= {winB[FILTER_TAPS-2:0], syncB[SYNC_DEPTH-1]};
    end
  end

  assign onesA = CW'($countones(winA));
  assign onesB = CW'($countones(winB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fltA <= 1'b0;
      fltB <= 1'b0;
      prvA <= 1'b0;
      prvB <= 1'b0;
    end else begin
      fltA <= (onesA >= CW'(MAJ));
      fltB <= (onesB >= CW'(MAJ));
      prvA <= fltA;
      prvB <= fltB;
    end
  end

  always_comb begin
    smp.fltA     = fltA;
    smp.fltB     = fltB;
    smp.prvA     = prvA;
    smp.prvB     = prvB;
    smp.rawA     = syncA[SYNC_DEPTH-1];
    smp.rawAPrev = winA[0];
    smp.rawB     = syncB[SYNC_DEPTH-1];
    smp.idx      = syncI[SYNC_DEPTH-1];
  end

endmodule

// File: rtl/quad_front_ctrl.sv
module quad_front_ctrl
  import quad_front_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sampleT     smp,
  input  logic       quadMode,
  input  logic [1:0] resSel,
  input  logic       idxSync,
  input  logic       idxPolarity,
  input  logic       clrNoise,
  output logic       countEn,
  output logic       countUp,
  output logic       dirUp,
  output logic       noiseErr,
  output logic       idxEvent
);

  resT  resEff;
  logic chgA, chgB, illegal, stepNext, upNext;
  logic syncEff, idxAct, idxNext;

  always_comb begin
    resEff = quadMode ? resT'(resSel) : RES_X1;
    if (resEff == RES_RSV) resEff = RES_X1;
    chgA     = smp.fltA ^ smp.prvA;
    chgB     = smp.fltB ^ smp.prvB;
    illegal  = 1'b0;
    stepNext = 1'b0;
    upNext   = 1'b0;
    if (quadMode) begin
      if (chgA && chgB) begin
        illegal = 1'b1;
      end else if (chgA) begin
        upNext   = smp.fltA ^ smp.fltB;
        stepNext = (resEff != RES_X1) || !smp.fltB;
      end else if (chgB) begin
        upNext   = ~(smp.fltA ^ smp.fltB);
        stepNext = (resEff == RES_X4);
      end
    end else begin
      stepNext = smp.rawA & ~smp.rawAPrev;
      upNext   = smp.rawB;
    end
    syncEff = quadMode & idxSync;
    idxAct  = (syncEff && idxPolarity) ? smp.idx : ~smp.idx;
    idxNext = syncEff ? (idxAct & stepNext) : idxAct;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countEn  <= 1'b0;
      countUp  <= 1'b0;
      dirUp    <= 1'b1;
      noiseErr <= 1'b0;
      idxEvent <= 1'b0;
    end else begin
      countEn  <= stepNext;
      countUp  <= stepNext & upNext;
      if (stepNext) dirUp <= upNext;
      if (illegal) noiseErr <= 1'b1;
      else if (clrNoise) noiseErr <= 1'b0;
      idxEvent <= idxNext;
    end
  end

endmodule

// File: rtl/quad_front.sv
module quad_front
  import quad_front_pkg::*;
#(
  parameter int SYNC_DEPTH  = 2,
  parameter int FILTER_TAPS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       encA,
  input  logic       encB,
  input  logic       encIdx,
  input  logic       quadMode,
  input  logic [1:0] resSel,
  input  logic       idxSync,
  input  logic       idxPolarity,
  input  logic       clrNoise,
  output logic       countEn,
  output logic       countUp,
  output logic       dirUp,
  output logic       noiseErr,
  output logic       idxEvent
);

  sampleT smp;

  quad_front_input #(
    .SYNC_DEPTH (SYNC_DEPTH),
    .FILTER_TAPS(FILTER_TAPS)
  ) input_i (
    .clk   (clk),
    .rstN  (rstN),
    .encA  (encA),
    .encB  (encB),
    .encIdx(encIdx),
    .smp   (smp)
  );

  quad_front_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .smp        (smp),
    .quadMode   (quadMode),
    .resSel     (resSel),
    .idxSync    (idxSync),
    .idxPolarity(idxPolarity),
    .clrNoise   (clrNoise),
    .countEn    (countEn),
    .countUp    (countUp),
    .dirUp      (dirUp),
    .noiseErr   (noiseErr),
    .idxEvent   (idxEvent)
  );

endmodule

// File: rtl/quad_front_chk.sv
module quad_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       quadMode,
  input logic       idxSync,
  input logic       clrNoise,
  input logic       countEn,
  input logic       countUp,
  input logic       dirUp,
  input logic       noiseErr,
  input logic       idxEvent
);

  assert_noise_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (noiseErr && !clrNoise) |=> noiseErr);

  assert_no_noise_nonquad_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!quadMode && !noiseErr) |=> !noiseErr);

  assert_dir_tracks_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    countEn |-> (dirUp == countUp));

  assert_sync_idx_on_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(quadMode && idxSync) && idxEvent) |-> countEn);

  assert_nonquad_single_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !quadMode && $past(!quadMode)) |=> !countEn);

endmodule

bind quad_front quad_front_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .quadMode(quadMode),
  .idxSync (idxSync),
  .clrNoise(clrNoise),
  .countEn (countEn),
  .countUp (countUp),
  .dirUp   (dirUp),
  .noiseErr(noiseErr),
  .idxEvent(idxEvent)
);

// File: tb/quad_front_tb_top.sv
module quad_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       encA = 1'b0, encB = 1'b0, encIdx = 1'b1;
  logic       quadMode = 1'b0;
  logic [1:0] resSel = 2'd0;
  logic       idxSync = 1'b0, idxPolarity = 1'b0, clrNoise = 1'b0;
  logic       countEn, countUp, dirUp, noiseErr, idxEvent;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string curReq = "R11";

  // reference model state
  logic [7:0] hA, hB, hI;
  logic [4:0] expVec;
  logic       mNoise, mDir;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_front dut_i (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .quadMode(quadMode), .resSel(resSel), .idxSync(idxSync),
    .idxPolarity(idxPolarity), .clrNoise(clrNoise),
    .countEn(countEn), .countUp(countUp), .dirUp(dirUp),
    .noiseErr(noiseErr), .idxEvent(idxEvent)
  );

  function automatic logic maj3(logic x, logic y, logic z);
    int n;
    n = int'(x) + int'(y) + int'(z);
    return n >= 2;
  endfunction

  always @(posedge clk) begin
    logic fa, fb, pa, pb, cnt, up, ill, se, act, ev;
    int   res;
    if (!rstN) begin
      hA = 8'h00; hB = 8'h00; hI = 8'hFF;
      mNoise = 1'b0; mDir = 1'b1;
      expVec = 5'b00100;
    end else begin
      hA = {hA[6:0], encA};
      hB = {hB[6:0], encB};
      hI = {hI[6:0], encIdx};
      cnt = 1'b0; up = 1'b0; ill = 1'b0;
      res = quadMode ? int'(resSel) : 0;
      if (res == 3) res = 0;
      if (quadMode) begin
        fa = maj3(hA[4], hA[5], hA[6]);
        pa = maj3(hA[5], hA[6], hA[7]);
        fb = maj3(hB[4], hB[5], hB[6]);
        pb = maj3(hB[5], hB[6], hB[7]);
        if (fa != pa && fb != pb) ill = 1'b1;
        else if (fa != pa) begin
          up  = (fa != fb);
          cnt = (res == 2) || (res == 1) || (fb == 1'b0);
        end else if (fb != pb) begin
          up  = (fa == fb);
          cnt = (res == 2);
        end
      end else begin
        cnt = hA[2] && !hA[3];
        up  = hB[2];
      end
      if (ill) mNoise = 1'b1;
      else if (clrNoise) mNoise = 1'b0;
      if (cnt) mDir = up;
      se  = quadMode && idxSync;
      act = (se && idxPolarity) ? hI[2] : !hI[2];
      ev  = se ? (act && cnt) : act;
      expVec = {cnt, cnt && up, mDir, mNoise, ev};
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if ({countEn, countUp, dirUp, noiseErr, idxEvent} !== expVec) begin
        failures++;
        $display("FAIL %s: {en,up,dir,noise,idx} actual=%b expected=%b at cycle %0d",
                 curReq, {countEn, countUp, dirUp, noiseErr, idxEvent}, expVec, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qs(logic a, logic b);
    encA = a; encB = b;
    hold(3);
  endtask

  task automatic fwd();
    qs(1, 0); qs(1, 1); qs(0, 1); qs(0, 0);
  endtask

  task automatic rev();
    qs(0, 1); qs(1, 1); qs(1, 0); qs(0, 0);
  endtask

  task automatic clkPulses(int n);
    for (int i = 0; i < n; i++) begin
      encA = 1'b1; hold(2);
      encA = 1'b0; hold(2);
    end
  endtask

  initial begin
    // R11: reset state seen on ports
    hold(3);
    checks++;
    if ({countEn, countUp, dirUp, noiseErr, idxEvent} !== 5'b00100) begin
      failures++;
      $display("FAIL R11: reset outputs actual=%b expected=00100",
               {countEn, countUp, dirUp, noiseErr, idxEvent});
    end
    rstN = 1'b1;
    hold(4);

    // R1: clock/direction mode, up then down
    curReq = "R1";
    encB = 1'b1; clkPulses(3);
    encB = 1'b0; clkPulses(3);
    hold(4);

    // R6: non-quadrature ignores resolution and sync index; R9 index level
    curReq = "R6";
    resSel = 2'd2; idxSync = 1'b1; idxPolarity = 1'b1;
    encB = 1'b1; clkPulses(2);
    encIdx = 1'b0; clkPulses(2);
    curReq = "R9";
    encIdx = 1'b1; hold(4);
    encIdx = 1'b0; hold(3);
    encIdx = 1'b1; hold(4);
    // R7: simultaneous change in non-quadrature mode leaves flag clear
    curReq = "R7";
    encA = 1'b1; encB = 1'b0; hold(3);
    encA = 1'b0; encB = 1'b1; hold(3);
    encA = 1'b0; encB = 1'b0; hold(6);

    // R3 / R8: quadrature x4 both directions
    idxSync = 1'b0; idxPolarity = 1'b0;
    quadMode = 1'b1; resSel = 2'd2;
    hold(8);
    curReq = "R3";
    fwd(); fwd();
    curReq = "R8";
    rev(); rev(); hold(6);

    // R4: x2
    curReq = "R4";
    resSel = 2'd1;
    fwd(); rev(); hold(6);

    // R5: x1 and reserved code
    curReq = "R5";
    resSel = 2'd0;
    fwd(); fwd(); rev();
    resSel = 2'd3;
    fwd(); rev(); hold(6);

    // R2: single-sample glitches are filtered out
    curReq = "R2";
    resSel = 2'd2;
    encA = 1'b1; hold(1); encA = 1'b0; hold(5);
    encB = 1'b1; hold(1); encB = 1'b0; hold(5);
    fwd(); hold(6);

    // R7: illegal jump, sticky flag, clear, clear against new error
    curReq = "R7";
    qs(1, 1); hold(6);
    qs(0, 0); hold(4);
    clrNoise = 1'b1; hold(1); clrNoise = 1'b0; hold(4);
    fwd(); hold(4);
    qs(1, 1); hold(3);
    clrNoise = 1'b1; hold(8); clrNoise = 1'b0;
    qs(0, 0); hold(6);
    clrNoise = 1'b1; hold(2); clrNoise = 1'b0; hold(4);

    // R10: synchronous index, both polarities
    curReq = "R10";
    idxSync = 1'b1; idxPolarity = 1'b1;
    encIdx = 1'b1; fwd();
    encIdx = 1'b0; fwd();
    idxPolarity = 1'b0;
    encIdx = 1'b0; rev();
    encIdx = 1'b1; rev();
    resSel = 2'd0; encIdx = 1'b0;
    fwd(); hold(6);

    // R9: back to non-synchronous index in quadrature mode
    curReq = "R9";
    idxSync = 1'b0;
    encIdx = 1'b1; hold(4);
    encIdx = 1'b0; fwd();
    encIdx = 1'b1; hold(6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule